// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block is purely combinational. It takes what an integer datapath knows after one operation and turns it into the six arithmetic status flags. The inputs are the two operands, the raw result, the carry or borrow out of the selected width, an operand-size code and an operation class. The flags come out twice: as individual signals, and packed into a 12-bit flags word where every flag has a fixed position. Three control bits from a separate input pass through unchanged into the upper part of the word.

Operands may be 8, 16, 32 or 64 bits wide. The sign, zero and overflow tests use the most-significant bit and the width that the size code selects. Result bits above that width are ignored. Parity and the auxiliary carry always look at the low end of the result, whatever the size. The block is placed directly after the adder or logic unit, and its word output feeds whatever register stores the flags.

Top module: `arith_flag_gen`

## Requirements
- R1: The packed word holds carry at bit 0, parity at bit 2, auxiliary at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. Each individual flag output equals its bit in the word.
- R2: Bit 1 of the word is always one, and bits 3 and 5 are always zero. The control input ctl_in[0], ctl_in[1] and ctl_in[2] appear unchanged at word bits 8, 9 and 10.
- R3: The size code picks the operand width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. The zero flag is set exactly when the result bits inside the selected width are all zero. Result bits above that width have no effect.
- R4: The sign flag equals the result bit at the top of the selected width.
- R5: The parity flag is set when result bits 7:0 hold an even number of ones, for every size code.
- R6: For add and subtract, the auxiliary flag is the carry or borrow into result bit 4, which is operand A bit 4 XOR operand B bit 4 XOR result bit 4.
- R7: For add and subtract, the carry flag equals the cy_in input, which is the carry-out of an add or the borrow of a subtract.
- R8: For add, overflow is set when both operands have the same sign at the selected width and the result sign differs from them.
- R9: For subtract, overflow is set when the operand signs differ and the result sign differs from that of operand A.
- R10: The operation codes are 0 for add, 1 for subtract and 2 for logic. Code 3 is treated as logic. A logic operation forces carry, auxiliary and overflow to zero, whatever the value of cy_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand (the subtrahend for a subtract) |
| res | input | 64 | Raw result from the datapath |
| cy_in | input | 1 | Carry-out of an add or borrow of a subtract at the selected width |
| size_code | input | 2 | Operand width: 0 for 8, 1 for 16, 2 for 32, 3 for 64 bits |
| op_kind | input | 2 | Operation class: 0 add, 1 subtract, 2 or 3 logic |
| ctl_in | input | 3 | Control bits copied into word bits 8 to 10 |
| flags | output | 12 | Packed flags word |
| cf | output | 1 | Carry flag |
| pf | output | 1 | Parity flag |
| af | output | 1 | Auxiliary carry flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Overflow flag |

## Verification
The bench places a 9-bit add result with its ninth bit set in the 64-bit result bus, and puts a 32-bit case whose only set bit is bit 63. A design that tests zero or takes the sign over the full bus would clear the zero flag or raise the sign in these cases. Signed overflow is driven across the 8-, 16- and 64-bit boundaries for both add and subtract. This catches a swapped subtract rule or an overflow taken from the wrong bit. Logic operations are applied with cy_in high and code 3 is used, so a leaked carry or an unhandled code shows up in the word. An all-zero case and a byte holding eight ones check parity and the fixed bits: a design that counts odd parity or moves a reserved bit would fail them.

// File: rtl/flag_pkg.sv
// Shared definitions for the arithmetic status flag generator.
// Assumes a flags word no wider than 12 bits and four operand sizes.
package flag_pkg;

    localparam int FLAGS_W  = 12;
    localparam int N_SIZES  = 4;

    // Bit positions inside the packed word; consumers decode these.
    localparam int POS_CF   = 0;
    localparam int POS_ONE  = 1;
    localparam int POS_PF   = 2;
    localparam int POS_AF   = 4;
    localparam int POS_ZF   = 6;
    localparam int POS_SF   = 7;
    localparam int POS_CTL0 = 8;
    localparam int POS_OF   = 11;
    localparam int CTL_W    = 3;

    typedef enum logic [1:0] {
        OPK_ADD   = 2'd0,
        OPK_SUB   = 2'd1,
        OPK_LOGIC = 2'd2,
        OPK_RSVD  = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flag_set_t;

endpackage

// File: rtl/flag_width_sel.sv
// Width-dependent tests: for each supported operand size it computes the
// zero test of the result and the top bits of A, B and the result, then
// picks the lane named by the size code.
// Assumes size i spans 8<<i bits and that the widest lane fits DATA_W.
module flag_width_sel #(
    parameter int DATA_W  = 64,
    parameter int N_SIZES = 4
) (
    input  logic [DATA_W-1:0]          a,
    input  logic [DATA_W-1:0]          b,
    input  logic [DATA_W-1:0]          r,
    input  logic [$clog2(N_SIZES)-1:0] size_code,
    output logic                       a_msb,
    output logic                       b_msb,
    output logic                       r_msb,
    output logic                       r_zero
);
    localparam int SEL_W = $clog2(N_SIZES);

    logic [N_SIZES-1:0] lane_zero;
    logic [N_SIZES-1:0] lane_am;
    logic [N_SIZES-1:0] lane_bm;
    logic [N_SIZES-1:0] lane_rm;

    genvar gi;
    generate
        for (gi = 0; gi < N_SIZES; gi++) begin : g_lane
            localparam int LW = 8 << gi;
            assign lane_zero[gi] = (r[LW-1:0] == '0);
            assign lane_am[gi]   = a[LW-1];
            assign lane_bm[gi]   = b[LW-1];
            assign lane_rm[gi]   = r[LW-1];
        end
    endgenerate

    // Pick the lane the size code names.
    always_comb begin
        a_msb  = 1'b0;
        b_msb  = 1'b0;
        r_msb  = 1'b0;
        r_zero = 1'b0;
        for (int i = 0; i < N_SIZES; i++) begin
            if (size_code == SEL_W'(i)) begin
                a_msb  = lane_am[i];
                b_msb  = lane_bm[i];
                r_msb  = lane_rm[i];
                r_zero = lane_zero[i];
            end
        end
    end

endmodule

// File: rtl/flag_parity_byte.sv
// Even-parity detector over one slice of the result.
// Assumes the caller passes only the low byte (or the width it wants tested).
module flag_parity_byte #(
    parameter int SLICE_W = 8
) (
    input  logic [SLICE_W-1:0] slice,
    output logic               even_ones
);
    logic [SLICE_W:0] chain;

    assign chain[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < SLICE_W; gi++) begin : g_chain
            assign chain[gi+1] = chain[gi] ^ slice[gi];
        end
    endgenerate

    // Chain starts at one, so an even count of ones leaves it at one.
    always_comb even_ones = chain[SLICE_W];

endmodule

// File: rtl/flag_arith.sv
// Carry, auxiliary and overflow flags from the operation class.
// Assumes the operand sign bits are already chosen for the active size and
// that cy_in already means borrow when the class is subtract.
module flag_arith
    import flag_pkg::*;
(
    input  op_kind_e op,
    input  logic     cy_in,
    input  logic     a_b4,
    input  logic     b_b4,
    input  logic     r_b4,
    input  logic     a_msb,
    input  logic     b_msb,
    input  logic     r_msb,
    output logic     cf,
    output logic     af,
    output logic     of
);
    logic half_cy;
    logic ovf_add;
    logic ovf_sub;

    // Carry into bit 4: same XOR for add and subtract.
    always_comb half_cy = a_b4 ^ b_b4 ^ r_b4;

    // Signed range tests for the two arithmetic classes.
    always_comb begin
        ovf_add = (a_msb == b_msb) && (r_msb != a_msb);
        ovf_sub = (a_msb != b_msb) && (r_msb != a_msb);
    end

    // Route by class; logic and the reserved code clear all three.
    always_comb begin
        unique case (op)
            OPK_ADD: begin
                cf = cy_in;
                af = half_cy;
                of = ovf_add;
            end
            OPK_SUB: begin
                cf = cy_in;
                af = half_cy;
                of = ovf_sub;
            end
            default: begin
                cf = 1'b0;
                af = 1'b0;
                of = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/arith_flag_gen.sv
// Top of the status flag generator. It combines the width selector, the
// parity detector and the arithmetic flag logic, and packs the six flags and
// the pass-through control bits into a fixed-layout 12-bit word.
// Assumes a purely combinational path and no storage.
module arith_flag_gen
    import flag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic [DATA_W-1:0]   res,
    input  logic                cy_in,
    input  logic [1:0]          size_code,
    input  logic [1:0]          op_kind,
    input  logic [CTL_W-1:0]    ctl_in,
    output logic [FLAGS_W-1:0]  flags,
    output logic                cf,
    output logic                pf,
    output logic                af,
    output logic                zf,
    output logic                sf,
    output logic                of
);
    logic      a_msb;
    logic      b_msb;
    logic      r_msb;
    logic      r_zero;
    logic      even_lo;
    flag_set_t fs;
    op_kind_e  op;

    // Interpret the raw operation code.
    always_comb op = op_kind_e'(op_kind);

    flag_width_sel #(
        .DATA_W (DATA_W),
        .N_SIZES(N_SIZES)
    ) u_width (
        .a        (op_a),
        .b        (op_b),
        .r        (res),
        .size_code(size_code),
        .a_msb    (a_msb),
        .b_msb    (b_msb),
        .r_msb    (r_msb),
        .r_zero   (r_zero)
    );

    flag_parity_byte #(
        .SLICE_W(8)
    ) u_par (
        .slice    (res[7:0]),
        .even_ones(even_lo)
    );

    flag_arith u_arith (
        .op    (op),
        .cy_in (cy_in),
        .a_b4  (op_a[4]),
        .b_b4  (op_b[4]),
        .r_b4  (res[4]),
        .a_msb (a_msb),
        .b_msb (b_msb),
        .r_msb (r_msb),
        .cf    (fs.cf),
        .af    (fs.af),
        .of    (fs.of)
    );

    // Width-driven and parity flags.
    always_comb begin
        fs.pf = even_lo;
        fs.zf = r_zero;
        fs.sf = r_msb;
    end

    // Lay the flags and control bits into the fixed word.
    always_comb begin
        flags           = '0;
        flags[POS_ONE]  = 1'b1;
        flags[POS_CF]   = fs.cf;
        flags[POS_PF]   = fs.pf;
        flags[POS_AF]   = fs.af;
        flags[POS_ZF]   = fs.zf;
        flags[POS_SF]   = fs.sf;
        flags[POS_OF]   = fs.of;
        for (int i = 0; i < CTL_W; i++) begin
            flags[POS_CTL0+i] = ctl_in[i];
        end
    end

    // Individual flag outputs.
    always_comb begin
        cf = fs.cf;
        pf = fs.pf;
        af = fs.af;
        zf = fs.zf;
        sf = fs.sf;
        of = fs.of;
    end

endmodule

// File: rtl/arith_flag_gen_chk.sv
// Checker for arith_flag_gen, bound to every instance. It relates the
// ports only, through immediate assertions, because the block holds no state.
module arith_flag_gen_chk (
    input logic [7:0]  res_lo,
    input logic [1:0]  op_kind,
    input logic [2:0]  ctl_in,
    input logic [11:0] flags,
    input logic        cf,
    input logic        pf,
    input logic        af,
    input logic        zf,
    input logic        sf,
    input logic        of
);
    // Check the port relations whenever any input or output moves.
    always_comb begin
        // R2
        fixed_bits_chk: assert (flags[1] && !flags[3] && !flags[5])
            else $error("fixed bits wrong: %h", flags);
        // R2
        ctl_pass_chk: assert (flags[10:8] == ctl_in)
            else $error("control bits not carried");
        // R1
        field_match_chk: assert (flags[0] == cf && flags[2] == pf && flags[4] == af
                                 && flags[6] == zf && flags[7] == sf && flags[11] == of)
            else $error("word and flag outputs disagree");
        // R10
        logic_clear_chk: assert (!(op_kind[1] && (cf || af || of)))
            else $error("logic op left carry, aux or overflow set");
        // R5
        zero_parity_chk: assert (!(res_lo == 8'h00 && !pf))
            else $error("zero low byte without parity");
        // R4
        zero_sign_chk: assert (!(zf && sf))
            else $error("zero and sign both set");
    end
endmodule

bind arith_flag_gen arith_flag_gen_chk u_flag_chk (
    .res_lo (res[7:0]),
    .op_kind(op_kind),
    .ctl_in (ctl_in),
    .flags  (flags),
    .cf     (cf),
    .pf     (pf),
    .af     (af),
    .zf     (zf),
    .sf     (sf),
    .of     (of)
);

// File: tb/sim_arith_flag_gen.sv
// Directed bench for arith_flag_gen: one task per scenario, with expected
// words worked out by hand from the requirements.
module sim_arith_flag_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a, op_b, res;
    logic        cy_in;
    logic [1:0]  size_code, op_kind;
    logic [2:0]  ctl_in;
    logic [11:0] flags;
    logic        cf, pf, af, zf, sf, of;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    arith_flag_gen u0 (
        .op_a(op_a), .op_b(op_b), .res(res), .cy_in(cy_in),
        .size_code(size_code), .op_kind(op_kind), .ctl_in(ctl_in),
        .flags(flags), .cf(cf), .pf(pf), .af(af), .zf(zf), .sf(sf), .of(of)
    );

    // Drive one vector on a falling edge and settle before checking.
    task automatic apply(input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] r, input logic c,
                         input logic [1:0] sz, input logic [1:0] k,
                         input logic [2:0] ct);
        @(negedge clk);
        op_a = a; op_b = b; res = r; cy_in = c;
        size_code = sz; op_kind = k; ctl_in = ct;
        #1;
    endtask

    // Compare the word and the individual flags against the expected word.
    task automatic expect_word(input string req, input logic [11:0] exp);
        logic [5:0] got_bits;
        logic [5:0] exp_bits;
        n_chk++;
        if (flags !== exp) begin
            n_err++;
            $display("FAIL %s: flags=%h expected %h", req, flags, exp);
        end
        got_bits = {of, sf, zf, af, pf, cf};
        exp_bits = {exp[11], exp[7], exp[6], exp[4], exp[2], exp[0]};
        n_chk++;
        if (got_bits !== exp_bits) begin
            n_err++;
            $display("FAIL R1 (%s): flag pins=%b expected %b", req, got_bits, exp_bits);
        end
    endtask

    // All-zero inputs: zero, parity and the fixed one bit (R2, R3, R5).
    task automatic t_idle();
        apply('0, '0, '0, 1'b0, 2'd3, 2'd0, 3'b000);
        expect_word("R2 idle word", 12'h046);
    endtask

    // 8-bit add 7F+01: overflow, sign, aux (R8, R6, R4).
    task automatic t_add8_ovf();
        apply(64'h7F, 64'h01, 64'h80, 1'b0, 2'd0, 2'd0, 3'b000);
        expect_word("R8 add8 overflow", 12'h892);
    endtask

    // 8-bit add FF+01 with result bit 8 set: carry and zero on low byte (R7, R3).
    task automatic t_add8_carry();
        apply(64'hFF, 64'h01, 64'h100, 1'b1, 2'd0, 2'd0, 3'b000);
        expect_word("R7 R3 add8 carry zero", 12'h057);
    endtask

    // 16-bit subtract 8000-0001: overflow and even parity of FF (R9, R5).
    task automatic t_sub16_ovf();
        apply(64'h8000, 64'h0001, 64'h7FFF, 1'b0, 2'd1, 2'd1, 3'b000);
        expect_word("R9 R5 sub16 overflow", 12'h816);
    endtask

    // 32-bit subtract 5-7: borrow and negative result (R7, R4, R6).
    task automatic t_sub32_borrow();
        apply(64'h5, 64'h7, 64'h0000_0000_FFFF_FFFE, 1'b1, 2'd2, 2'd1, 3'b000);
        expect_word("R7 R4 sub32 borrow", 12'h093);
    endtask

    // 64-bit add of two minimum values: carry, zero, overflow (R8, R3).
    task automatic t_add64_wrap();
        apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 1'b1,
              2'd3, 2'd0, 3'b000);
        expect_word("R8 add64 wrap", 12'h847);
    endtask

    // Logic op with cy_in high: carry, aux and overflow cleared (R10).
    task automatic t_logic();
        apply(64'h10, 64'h0, 64'h10, 1'b1, 2'd0, 2'd2, 3'b000);
        expect_word("R10 logic clears", 12'h002);
        apply(64'h7F, 64'h7F, 64'h10, 1'b1, 2'd0, 2'd3, 3'b000);
        expect_word("R10 reserved code as logic", 12'h002);
    endtask

    // Control bits appear at 8 to 10 unchanged (R2).
    task automatic t_ctl();
        apply('0, '0, '0, 1'b0, 2'd3, 2'd0, 3'b101);
        expect_word("R2 ctl 101", 12'h546);
        apply('0, '0, '0, 1'b0, 2'd3, 2'd0, 3'b010);
        expect_word("R2 ctl 010", 12'h246);
    endtask

    // 32-bit size ignores bit 63 for zero and sign (R3, R4).
    task automatic t_size32_upper();
        apply('0, '0, 64'h8000_0000_0000_0000, 1'b0, 2'd2, 2'd0, 3'b000);
        expect_word("R3 R4 size32 upper ignored", 12'h046);
    endtask

    // 16-bit sign at bit 15 with add overflow (R4, R8).
    task automatic t_sign16();
        apply(64'h4000, 64'h4000, 64'h8000, 1'b0, 2'd1, 2'd0, 3'b000);
        expect_word("R4 R8 sign16", 12'h886);
    endtask

    // Odd parity byte clears parity (R5).
    task automatic t_parity_odd();
        apply('0, '0, 64'h0000_0000_0000_0107, 1'b0, 2'd1, 2'd0, 3'b000);
        expect_word("R5 odd parity", 12'h002);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        op_a = '0; op_b = '0; res = '0; cy_in = 1'b0;
        size_code = 2'd3; op_kind = 2'd0; ctl_in = '0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_add8_ovf();
        t_add8_carry();
        t_sub16_ovf();
        t_sub32_borrow();
        t_add64_wrap();
        t_logic();
        t_ctl();
        t_size32_upper();
        t_sign16();
        t_parity_odd();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule